// File: doc/BRIEF.md
# Watchdog Expiry Event Router

This block sits next to a watchdog counter and decides what the system sees when that counter runs out. A host reaches it through a byte-wide I/O port with separate write and read strobes. An event-control register at 4004h holds a 3-bit code that picks one of five interrupt request lines, plus a bit that lets the expiry drive a reset output. A status register at 4005h holds a sticky expiry flag. A host read of the stop port at 4002h halts the watchdog. A dedicated stop request input does the same.

When the counter signals expiry with a one-cycle pulse, the block registers the event. The alarm output always asserts. The reset output asserts only when enabled. At most one interrupt line asserts, chosen by the code. The routing and the reset enable are captured at the moment of expiry. All event outputs then stay high as levels until the watchdog is stopped. The host can reprogram the event-control register at any time without moving an event that is already asserted.

Top module: `wdt_event_router`

## Requirements
- R1: After reset the event-control bits [3:0] are 0, the expiry flag is 0, and `irq_lines`, `reset_out` and `alarm_out` are all low.
- R2: A write to address 4004h stores `host_wdata[3:0]`. A read of 4004h returns those four bits in [3:0], and bits [7:4] read as 0.
- R3: On expiry, code bits [2:0] route the event to one interrupt line. Code 1 selects `irq_lines[0]` (IRQ5), 2 selects `[1]` (IRQ7), 3 selects `[2]` (IRQ9), 4 selects `[3]` (IRQ10) and 5 selects `[4]` (IRQ11). No other line asserts.
- R4: Codes 0, 6 and 7 leave every interrupt line low on expiry.
- R5: On expiry, `reset_out` asserts if and only if bit 3 of the event-control register is 1.
- R6: Every expiry asserts `alarm_out`, whatever the code and the reset-enable bit hold.
- R7: A read of 4005h returns the expiry flag in bit 0 and 0 in bits [7:1]. Writes to 4005h change nothing.
- R8: A host read of 4002h, or a high `stop_req`, clears the flag and all event outputs at the next clock edge. If stop and expiry fall in the same cycle, the stop wins.
- R9: Event outputs appear in the cycle after the expiry pulse and hold until a stop. The routing and reset enable are captured at expiry, so these do not move the asserted event: a register write (including one in the same cycle as the expiry) and further expiry pulses.
- R10: A read with `host_rd` low, or a read of any other address, returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_addr | input | 16 | Host I/O address |
| host_wdata | input | 8 | Host write data |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe |
| host_rdata | output | 8 | Host read data, combinational from the address |
| expiry_pulse | input | 1 | One-cycle timeout pulse from the counter |
| stop_req | input | 1 | Watchdog stop request |
| irq_lines | output | 5 | Interrupt requests for IRQ5, IRQ7, IRQ9, IRQ10 and IRQ11 |
| reset_out | output | 1 | Reset request on expiry |
| alarm_out | output | 1 | Unconditional alarm on expiry |

## Verification
The bench sweeps all eight codes against both reset-enable settings and both stop methods. A decoder shifted by one line, or one that treats codes 6 and 7 as valid, would show up on the wrong interrupt line. A stop that lost to a simultaneous expiry would leave the alarm latched. A router that fed the live register to the outputs, rather than the value captured at expiry, would move an asserted interrupt when the host rewrites the code. So would a second expiry pulse that was allowed to resample. Status-register writes and upper event-control bits are checked through read-back to catch stray storage.

// File: rtl/wdt_router_pkg.sv
package wdt_router_pkg;
    localparam int ADDR_W   = 16;
    localparam int DATA_W   = 8;
    localparam int CODE_W   = 3;
    localparam int CFG_W    = CODE_W + 1;
    localparam int IRQ_N    = 5;
    localparam logic [ADDR_W-1:0] ADDR_STOP   = 16'h4002;
    localparam logic [ADDR_W-1:0] ADDR_EVENT  = 16'h4004;
    localparam logic [ADDR_W-1:0] ADDR_STATUS = 16'h4005;

    typedef struct packed {
        logic             rst_en;
        logic [CODE_W-1:0] code;
    } evt_cfg_t;

    typedef struct packed {
        logic             expired;
        logic             alarm;
        logic             rst;
        logic [IRQ_N-1:0] irq;
    } evt_state_t;
endpackage

// File: rtl/wdt_cfg_regs.sv
module wdt_cfg_regs
    import wdt_router_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int DW = DATA_W,
    parameter logic [AW-1:0] EVT_ADDR = ADDR_EVENT
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    input  logic          wr,
    output evt_cfg_t      cfg_q
);
    evt_cfg_t cfg_d;

    always_comb begin
        cfg_d = cfg_q;
        if (wr && addr == EVT_ADDR)
            cfg_d = evt_cfg_t'(wdata[CFG_W-1:0]);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    // R2: a write to the event register is visible on the next cycle
    a_r2_write_stores: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && addr == EVT_ADDR) |=> (cfg_q == $past(wdata[CFG_W-1:0])));

    // R2: without a write to it the register keeps its value
    a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr && addr == EVT_ADDR) |=> $stable(cfg_q));
endmodule

// File: rtl/wdt_route_decode.sv
module wdt_route_decode
    import wdt_router_pkg::*;
#(
    parameter int CW = CODE_W,
    parameter int N  = IRQ_N
) (
    input  logic [CW-1:0] code,
    output logic [N-1:0]  route
);
    // Code value i+1 selects line i; every other code selects nothing.
    for (genvar i = 0; i < N; i++) begin : g_line
        assign route[i] = (code == CW'(i + 1));
    end
endmodule

// File: rtl/wdt_event_latch.sv
module wdt_event_latch
    import wdt_router_pkg::*;
#(
    parameter int N = IRQ_N
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         expiry,
    input  logic         stop,
    input  logic         rst_en,
    input  logic [N-1:0] route,
    output evt_state_t   st_q
);
    evt_state_t st_d;

    always_comb begin
        st_d = st_q;
        if (stop) begin
            st_d = '0;
        end else if (expiry && !st_q.expired) begin
            st_d.expired = 1'b1;
            st_d.alarm   = 1'b1;
            st_d.rst     = rst_en;
            st_d.irq     = route;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R3: never more than one interrupt line
    a_r3_one_line: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(st_q.irq));

    // R6: any expiry not cancelled by a stop raises the alarm
    a_r6_alarm_on_expiry: assert property (@(posedge clk) disable iff (!rst_n)
        (expiry && !stop) |=> st_q.alarm);

    // R5: reset and interrupts only appear together with the alarm
    a_r5_rst_needs_alarm: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.rst || st_q.irq != '0) |-> st_q.alarm);

    // R8: stop clears everything at the next edge
    a_r8_stop_clears: assert property (@(posedge clk) disable iff (!rst_n)
        stop |=> (!st_q.alarm && !st_q.rst && st_q.irq == '0 && !st_q.expired));

    // R9: an asserted event holds until stop
    a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.alarm && !stop) |=> (st_q.alarm && $stable(st_q.irq) && $stable(st_q.rst)));
endmodule

// File: rtl/wdt_event_router.sv
module wdt_event_router
    import wdt_router_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [DATA_W-1:0] host_wdata,
    input  logic              host_wr,
    input  logic              host_rd,
    output logic [DATA_W-1:0] host_rdata,
    input  logic              expiry_pulse,
    input  logic              stop_req,
    output logic [IRQ_N-1:0]  irq_lines,
    output logic              reset_out,
    output logic              alarm_out
);
    evt_cfg_t         cfg_q;
    evt_state_t       st_q;
    logic [IRQ_N-1:0] route;
    logic             stop;

    assign stop = stop_req || (host_rd && host_addr == ADDR_STOP);

    wdt_cfg_regs #(.AW(ADDR_W), .DW(DATA_W), .EVT_ADDR(ADDR_EVENT)) i_cfg (
        .clk   (clk),
        .rst_n (rst_n),
        .addr  (host_addr),
        .wdata (host_wdata),
        .wr    (host_wr),
        .cfg_q (cfg_q)
    );

    wdt_route_decode #(.CW(CODE_W), .N(IRQ_N)) i_dec (
        .code  (cfg_q.code),
        .route (route)
    );

    wdt_event_latch #(.N(IRQ_N)) i_latch (
        .clk    (clk),
        .rst_n  (rst_n),
        .expiry (expiry_pulse),
        .stop   (stop),
        .rst_en (cfg_q.rst_en),
        .route  (route),
        .st_q   (st_q)
    );

    always_comb begin
        host_rdata = '0;
        if (host_rd) begin
            if (host_addr == ADDR_EVENT)
                host_rdata = DATA_W'(cfg_q);
            else if (host_addr == ADDR_STATUS)
                host_rdata = DATA_W'(st_q.expired);
        end
    end

    assign irq_lines = st_q.irq;
    assign reset_out = st_q.rst;
    assign alarm_out = st_q.alarm;

    // R10: idle read port returns zero
    a_r10_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !host_rd |-> (host_rdata == '0));

    // R7: status read mirrors the alarm state, upper bits zero
    a_r7_status_bits: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rd && host_addr == ADDR_STATUS) |-> (host_rdata == DATA_W'(alarm_out)));
endmodule

// File: tb/test_wdt_event_router.sv
`timescale 1ns/1ps
module test_wdt_event_router;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] host_addr = '0;
    logic [7:0]  host_wdata = '0;
    logic        host_wr = 1'b0;
    logic        host_rd = 1'b0;
    logic [7:0]  host_rdata;
    logic        expiry_pulse = 1'b0;
    logic        stop_req = 1'b0;
    logic [4:0]  irq_lines;
    logic        reset_out;
    logic        alarm_out;

    int n_checks = 0;
    int n_fail   = 0;
    int cycles   = 0;

    always #4 clk = ~clk;

    wdt_event_router i_wdt_event_router (
        .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_wdata(host_wdata),
        .host_wr(host_wr), .host_rd(host_rd), .host_rdata(host_rdata),
        .expiry_pulse(expiry_pulse), .stop_req(stop_req), .irq_lines(irq_lines),
        .reset_out(reset_out), .alarm_out(alarm_out)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic logic [4:0] exp_irq(input int code);
        return (code >= 1 && code <= 5) ? 5'(1 << (code - 1)) : 5'd0;
    endfunction

    task automatic wr(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk); host_addr = a; host_wdata = d; host_wr = 1'b1;
        @(negedge clk); host_wr = 1'b0;
    endtask

    task automatic rd_chk(input logic [15:0] a, input logic [7:0] exp, input string tag);
        @(negedge clk); host_addr = a; host_rd = 1'b1;
        #1 check(tag, host_rdata, exp);
        @(negedge clk); host_rd = 1'b0;
    endtask

    task automatic fire;
        @(negedge clk); expiry_pulse = 1'b1;
        @(negedge clk); expiry_pulse = 1'b0;
    endtask

    task automatic do_stop(input bit by_read);
        @(negedge clk);
        if (by_read) begin host_addr = 16'h4002; host_rd = 1'b1; end
        else stop_req = 1'b1;
        @(negedge clk); host_rd = 1'b0; stop_req = 1'b0;
    endtask

    task automatic check_outs(input logic [4:0] irq, input logic rs, input logic al, input string tag);
        check({tag, " irq"},   irq_lines, irq);
        check({tag, " reset"}, reset_out, rs);
        check({tag, " alarm"}, alarm_out, al);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check_outs(5'd0, 1'b0, 1'b0, "R1");
        rd_chk(16'h4004, 8'h00, "R1 event reg");
        rd_chk(16'h4005, 8'h00, "R1 status");

        // R2 write/read, upper bits read 0
        wr(16'h4004, 8'hFA);
        rd_chk(16'h4004, 8'h0A, "R2 readback");
        // R10 idle and foreign addresses
        #1 check("R10 idle rdata", host_rdata, 8'h00);
        rd_chk(16'h4003, 8'h00, "R10 other addr");
        // R7 status writes ignored before expiry
        wr(16'h4005, 8'hFF);
        rd_chk(16'h4005, 8'h00, "R7 status write ignored");

        // R3 R4 R5 R6 R8 sweep
        for (int m = 0; m < 2; m++) begin
            for (int code = 0; code < 8; code++) begin
                for (int re = 0; re < 2; re++) begin
                    wr(16'h4004, 8'((re << 3) | code));
                    check_outs(5'd0, 1'b0, 1'b0, "R9 no event before expiry");
                    fire();
                    check_outs(exp_irq(code), 1'(re), 1'b1,
                               (code >= 1 && code <= 5) ? "R3 route" : "R4 suppress");
                    rd_chk(16'h4005, 8'h01, "R7 flag set");
                    do_stop(m[0]);
                    check_outs(5'd0, 1'b0, 1'b0, "R8 stop clears");
                    rd_chk(16'h4005, 8'h00, "R8 flag cleared");
                end
            end
        end

        // R8 stop wins same cycle
        wr(16'h4004, 8'h0B);
        @(negedge clk); expiry_pulse = 1'b1; stop_req = 1'b1;
        @(negedge clk); expiry_pulse = 1'b0; stop_req = 1'b0;
        check_outs(5'd0, 1'b0, 1'b0, "R8 stop beats expiry");
        rd_chk(16'h4005, 8'h00, "R8 flag after tie");

        // R9 captured at expiry; rewrite and re-expiry do not move it
        wr(16'h4004, 8'h02);
        fire();
        check_outs(5'b00010, 1'b0, 1'b1, "R9 captured");
        wr(16'h4004, 8'h0D);
        check_outs(5'b00010, 1'b0, 1'b1, "R9 rewrite holds");
        fire();
        check_outs(5'b00010, 1'b0, 1'b1, "R9 re-expiry holds");
        wr(16'h4005, 8'h00);
        rd_chk(16'h4005, 8'h01, "R7 status write ignored while set");
        repeat (5) @(negedge clk);
        check_outs(5'b00010, 1'b0, 1'b1, "R9 level hold");
        do_stop(1'b1);
        check_outs(5'd0, 1'b0, 1'b0, "R8 read stop");

        // R9 write in the same cycle as expiry: old value used
        wr(16'h4004, 8'h01);
        @(negedge clk); host_addr = 16'h4004; host_wdata = 8'h0C; host_wr = 1'b1; expiry_pulse = 1'b1;
        @(negedge clk); host_wr = 1'b0; expiry_pulse = 1'b0;
        check_outs(5'b00001, 1'b0, 1'b1, "R9 same-cycle write");
        rd_chk(16'h4004, 8'h0C, "R2 same-cycle write stored");
        do_stop(1'b0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule